// File: doc/BRIEF.md
# Delay-Select Code Programming Interface

This block holds the 8-bit code that picks a tap in a programmable delay chain. Code 0 selects the shortest, inherent delay, and each higher code adds one equal step, so there are 256 settings. The block is a synchronous model. The system clock samples the enable line and the serial clock, and an edge on either is detected from one sample to the next.

A mode input picks the source of the code. With the mode input at 1, the code comes from eight parallel pins. Those pins pass straight through while the enable is high, and the block captures them when the enable falls.

With the mode input at 0, a three-wire shift port loads an input register, most significant bit first. The falling edge of the enable commits that register to the active code. While the enable is high, the register's old contents leave on a serial output, so a host can read the setting back or chain several units. A one-cycle update strobe tells the downstream tap selector that the code has changed.

Top module: `dly_prog_if`

## Requirements
- R1: While `rstN` is sampled low, the block clears the active code and the input register to 0 and holds `sdOut` and `codeUpd` at 0.
- R2: With `modeSel`=1 and `enIn` high, the active code equals the `parIn` value sampled at the previous clock edge (transparent parallel mode).
- R3: With `modeSel`=1, the first clock that samples `enIn` low after it was high captures `parIn` into the code. Later changes on `parIn` while `enIn` stays low leave the code unchanged.
- R4: With `modeSel`=0, each rising `sclkIn` that the clock sees while `enIn` is high shifts the input register left by one. `sdIn` enters at bit 0, so after eight edges the first bit sent sits in bit 7. Rising `sclkIn` edges while `enIn` is low do not change the register.
- R5: With `modeSel`=0, the active code does not change while the register shifts. On the first clock that samples `enIn` low after it was high, the code takes the full 8-bit register value. Any value from 0 to 255 is valid.
- R6: One clock after `enIn` is sampled high, `sdOut` shows bit 7 of the input register. After each shift it shows the next older bit, so a read empties the register MSB first and destroys its contents.
- R7: `sdOut` is 0 in any cycle whose previous clock sampled `enIn` low.
- R8: `codeUpd` is high for exactly the cycles in which `codeOut` differs from its value one clock earlier.
- R9: When one unit's `sdOut` feeds the next unit's `sdIn`, sixteen bits shifted under one enable window leave the first byte sent in the far unit and the second byte in the near unit. Both units commit their bytes on the enable fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 1 | 1 = parallel source, 0 = serial source |
| enIn | input | 1 | Enable: gates shifting, commits on its fall, selects transparent or latched parallel mode |
| sclkIn | input | 1 | Serial shift clock (sampled) |
| sdIn | input | 1 | Serial data in, MSB first |
| parIn | input | 8 | Parallel code pins |
| sdOut | output | 1 | Serial data out; held low while the enable is low |
| codeOut | output | 8 | Active delay-select code |
| codeUpd | output | 1 | One-cycle pulse when the active code changes |

## Verification
A corrupted input register stays hidden until the next enable window. It then shows on `sdOut` one clock after the enable is sampled high, and after the following enable fall it shows on `codeOut`. A wrong active code is visible on `codeOut` at once, and a missed or extra change shows in the same cycle as a `codeUpd` that disagrees with the code's movement. Mis-detected edges on the enable or serial clock show up in the same way: the read-back bits and the committed code come out shifted by one position.

// File: rtl/dly_prog_pkg.sv
package dly_prog_pkg;
  parameter int CODE_W = 8;

  typedef struct packed {
    logic shiftEn;
    logic loadSer;
    logic loadPar;
    logic drvOut;
  } progStb_t;
endpackage

// File: rtl/dly_prog_ctrl.sv
module dly_prog_ctrl
  import dly_prog_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeSel,
  input  logic     enIn,
  input  logic     sclkIn,
  output progStb_t stb
);
  logic enQ;
  logic sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      sclkQ <= 1'b0;
    end else begin
      enQ   <= enIn;
      sclkQ <= sclkIn;
    end
  end

  logic enFall;
  logic sclkRise;
  assign enFall   = enQ & ~enIn;
  assign sclkRise = sclkIn & ~sclkQ;

  always_comb begin
    stb.shiftEn = ~modeSel & enIn & sclkRise;
    stb.loadSer = ~modeSel & enFall;
    stb.loadPar = modeSel & (enIn | enQ);
    stb.drvOut  = enQ;
  end
endmodule

// File: rtl/dly_prog_dp.sv
module dly_prog_dp
  import dly_prog_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  progStb_t     stb,
  input  logic         sdIn,
  input  logic [W-1:0] parIn,
  output logic         sdOut,
  output logic [W-1:0] codeOut,
  output logic         codeUpd
);
  logic [W-1:0] shiftReg;
  logic [W-1:0] codeNxt;
  logic         doLoad;

  assign doLoad  = stb.loadSer | stb.loadPar;
  assign codeNxt = stb.loadPar ? parIn : shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      codeOut  <= '0;
      codeUpd  <= 1'b0;
    end else begin
      if (stb.shiftEn) shiftReg <= {shiftReg[W-2:0], sdIn};
      if (doLoad) codeOut <= codeNxt;
      codeUpd <= doLoad && (codeNxt != codeOut);
    end
  end

  assign sdOut = stb.drvOut & shiftReg[W-1];
endmodule

// File: rtl/dly_prog_if.sv
module dly_prog_if
  import dly_prog_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeSel,
  input  logic         enIn,
  input  logic         sclkIn,
  input  logic         sdIn,
  input  logic [W-1:0] parIn,
  output logic         sdOut,
  output logic [W-1:0] codeOut,
  output logic         codeUpd
);
  progStb_t stb;

  dly_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .enIn(enIn), .sclkIn(sclkIn), .stb(stb)
  );

  dly_prog_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdIn(sdIn), .parIn(parIn),
    .sdOut(sdOut), .codeOut(codeOut), .codeUpd(codeUpd)
  );
endmodule

// File: rtl/dly_prog_if_chk.sv
module dly_prog_if_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         modeSel,
  input logic         enIn,
  input logic [W-1:0] parIn,
  input logic         sdOut,
  input logic [W-1:0] codeOut,
  input logic         codeUpd
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (codeOut == '0 && !codeUpd && !sdOut));

  // R7
  a_r7_out_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enIn) |-> !sdOut);

  // R8
  a_r8_upd_has_change: assert property (@(posedge clk) disable iff (!rstN)
    codeUpd |-> codeOut != $past(codeOut));

  // R8
  a_r8_change_has_upd: assert property (@(posedge clk) disable iff (!rstN)
    codeOut != $past(codeOut) |-> codeUpd);

  // R2
  a_r2_transparent: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) && $past(enIn) && $past(rstN)) |-> codeOut == $past(parIn));

  // R5
  a_r5_serial_commit_only_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!modeSel) && codeOut != $past(codeOut)) |-> ($past(!enIn) && $past(enIn, 2)));
endmodule

bind dly_prog_if dly_prog_if_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .enIn(enIn), .parIn(parIn),
  .sdOut(sdOut), .codeOut(codeOut), .codeUpd(codeUpd)
);

// File: tb/sim_dly_prog_if.sv
module sim_dly_prog_if;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic enIn = 1'b0;
  logic sclkIn = 1'b0;
  logic sdIn = 1'b0;
  logic [7:0] parIn = 8'h00;
  logic sdOut0, sdOut1, upd0, upd1;
  logic [7:0] code0, code1;

  always #2 clk = ~clk;

  dly_prog_if u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .enIn(enIn), .sclkIn(sclkIn),
    .sdIn(sdIn), .parIn(parIn), .sdOut(sdOut0), .codeOut(code0), .codeUpd(upd0)
  );

  dly_prog_if u1 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .enIn(enIn), .sclkIn(sclkIn),
    .sdIn(sdOut0), .parIn(parIn), .sdOut(sdOut1), .codeOut(code1), .codeUpd(upd1)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] expCode = 8'h00;
  logic [7:0] expSr = 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic updExp(input logic [7:0] oldC, input logic [7:0] newC);
    return oldC != newC;
  endfunction

  // serial write of one byte, checking destructive readback (R4, R5, R6, R7, R8)
  task automatic serWrite(input logic [7:0] v);
    logic [7:0] rd;
    modeSel = 1'b0;
    enIn = 1'b1;
    tick();
    for (int k = 7; k >= 0; k--) begin
      rd[k] = sdOut0;
      sdIn = v[k];
      sclkIn = 1'b1;
      tick();
      sclkIn = 1'b0;
      tick();
      chk("R5 code held while shifting", code0, expCode);
    end
    chk("R6 readback old register", rd, expSr);
    enIn = 1'b0;
    tick();
    chk("R5 serial commit", code0, v);
    chk("R8 update on serial commit", upd0, updExp(expCode, v));
    expCode = v;
    expSr = v;
    tick();
    chk("R7 sdOut low when idle", sdOut0, 1'b0);
    chk("R8 update single cycle", upd0, 1'b0);
  endtask

  task automatic parTransparent(input logic [7:0] v);
    modeSel = 1'b1;
    enIn = 1'b1;
    parIn = v;
    tick();
    chk("R2 transparent follows pins", code0, v);
    chk("R8 update transparent", upd0, updExp(expCode, v));
    expCode = v;
    enIn = 1'b0;
    tick();
    chk("R3 fall keeps same pins", code0, v);
    chk("R8 no update without change", upd0, 1'b0);
  endtask

  task automatic parLatched(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    modeSel = 1'b1;
    enIn = 1'b1;
    parIn = a;
    tick();
    expCode = a;
    enIn = 1'b0;
    parIn = b;
    tick();
    chk("R3 capture on enable fall", code0, b);
    chk("R8 update on latch", upd0, updExp(a, b));
    expCode = b;
    parIn = c;
    tick();
    tick();
    chk("R3 pins ignored while latched", code0, b);
    chk("R8 no update while latched", upd0, 1'b0);
  endtask

  initial begin
    // R1: reset state
    tick();
    tick();
    chk("R1 code reset", code0, 8'h00);
    chk("R1 update reset", upd0, 1'b0);
    chk("R1 sdOut reset", sdOut0, 1'b0);
    rstN = 1'b1;
    tick();

    // directed corners of the code range
    serWrite(8'hFF);
    serWrite(8'h00);
    serWrite(8'h80);
    serWrite(8'h01);
    serWrite(8'h01);
    parTransparent(8'h5A);
    parLatched(8'h11, 8'hC3, 8'h3C);

    // R4: serial clock edges while the enable is low are ignored
    modeSel = 1'b0;
    enIn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sdIn = k[0];
      sclkIn = 1'b1;
      tick();
      chk("R7 sdOut low with enable low", sdOut0, 1'b0);
      sclkIn = 1'b0;
      tick();
    end
    serWrite(8'h6D);  // readback must still show 8'h01

    // R4: MSB-first placement, seen through readback
    serWrite(8'hB2);
    modeSel = 1'b0;
    enIn = 1'b1;
    tick();
    chk("R4 first bit sent lands in bit 7", sdOut0, 1'b1);
    sdIn = 1'b0;
    sclkIn = 1'b1;
    tick();
    chk("R4 R6 next bit after one shift", sdOut0, 1'b0);
    sclkIn = 1'b0;
    tick();
    sclkIn = 1'b1;
    tick();
    chk("R4 R6 third bit after two shifts", sdOut0, 1'b1);
    sclkIn = 1'b0;
    enIn = 1'b0;
    tick();
    // the register is now 8'hB2 shifted left twice with zeros in
    chk("R6 destructive read commit", code0, 8'hC8);
    expCode = 8'hC8;
    expSr = 8'hC8;
    tick();

    // R9: two chained units, 16 bits under one enable window
    begin
      logic [7:0] first;
      logic [7:0] second;
      logic [15:0] stream;
      first = 8'hA7;
      second = 8'h3E;
      stream = {first, second};
      modeSel = 1'b0;
      enIn = 1'b1;
      tick();
      for (int k = 15; k >= 0; k--) begin
        sdIn = stream[k];
        sclkIn = 1'b1;
        tick();
        sclkIn = 1'b0;
        tick();
      end
      enIn = 1'b0;
      tick();
      chk("R9 near unit holds second byte", code0, second);
      chk("R9 far unit holds first byte", code1, first);
      expCode = second;
      expSr = second;
      tick();
    end

    // constrained random mix
    void'($urandom(32'd7741));
    for (int n = 0; n < 150; n++) begin
      logic [1:0] op;
      logic [7:0] v;
      op = 2'($urandom_range(0, 2));
      v = 8'($urandom());
      case (op)
        2'd0: serWrite(v);
        2'd1: parTransparent(v);
        default: parLatched(8'($urandom()), v, 8'($urandom()));
      endcase
    end

    // R1: reset clears the input register too
    serWrite(8'hA5);
    rstN = 1'b0;
    tick();
    tick();
    chk("R1 code cleared by reset", code0, 8'h00);
    rstN = 1'b1;
    expCode = 8'h00;
    expSr = 8'h00;
    tick();
    serWrite(8'h42);  // readback checks a cleared register

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule